// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines and turns them into two processor-facing requests: a fast request and a normal request. Each source can be enabled or masked, and each is steered to one of the two outputs. For normal requests the block returns a handler address. It does this through a bank of prioritised vector slots. Each slot pairs an address word with a control word. The control word names one request source and carries a slot-enable flag.

Software works through a small register bus. An interrupt handler first reads the current-vector register. That read returns the handler address of the winning slot, or the default address when no enabled slot matches. The same read marks the winner as in service. While a slot is in service, only requests from strictly higher-priority slots can raise the normal output again. A write of any value to the current-vector register ends service of the most recently latched level and re-arms the priority logic.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, both request outputs are low. All enables, routes, slot words and the default address read as zero, and no level is in service.
- R2: A write to offset 0x04 sets every enable bit written as 1, and a write to offset 0x08 clears every enable bit written as 1. Bits written as 0 leave their enable unchanged. Reading offset 0x04 returns the enable mask.
- R3: Reading offset 0x00 returns the request lines as they arrive, before masking. A masked line raises no output.
- R4: Route register bit n (offset 0x0C) steers source n: 1 selects the fast output and 0 selects the normal output. The fast output is high exactly when some pending, enabled source is routed fast.
- R5: Slot k has its address word at 0x40+4k and its control word at 0x80+4k. Control bits 4:0 name the source and bit 5 enables the slot. An enabled slot whose source is pending, enabled and routed normal matches. The current vector (and a read of 0x10) then returns its address. A slot with bit 5 clear never matches.
- R6: When several slots match, the lowest-numbered slot wins. This holds when two slots name the same source.
- R7: When a normal request is pending and no enabled slot matches, the current vector returns the default address at offset 0x14. The default level ranks below every slot.
- R8: A read of offset 0x10 while the normal output is high marks the winning level as in service. From then on, only slots numbered strictly lower than the lowest level in service can raise the normal output.
- R9: A write of any data to offset 0x10 removes the highest-priority level from service. Pending requests that it was masking are then presented again. Such a write with nothing in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_SRC | Level request lines, one per source |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational in the access cycle |
| irq_req_o | output | 1 | Normal interrupt request |
| fiq_req_o | output | 1 | Fast interrupt request |
| cur_vector | output | DATA_W | Current vector address value |

## Verification
Read data, the request outputs and the current vector are combinational. Reads are sampled one time unit after the strobe is applied, before the clock edge that commits side effects. Register writes, enable changes and in-service updates take effect at the edge that ends the access. Their outputs are sampled at the following falling edge. A change on the request lines alone reaches the outputs in the same cycle. The bench samples those outputs one time unit after the change, and the sequences that exercise nesting interleave source changes, latching reads and end-of-service writes, checking after each one.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ENSET  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ENCLR  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_ROUTE  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CURVEC = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_DFLT   = 8'h14;

    // slot regions: address words in 0x40..0x7C, control words in 0x80..0xBC
    localparam logic [1:0] REG_SLOT_ADDR = 2'b01;
    localparam logic [1:0] REG_SLOT_CTRL = 2'b10;
endpackage

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vic_slot_match.sv
module vic_slot_match #(
    parameter int NUM_SRC  = 22,
    parameter int NUM_SLOT = 16,
    parameter int SRC_W    = 5
) (
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SLOT-1:0][SRC_W-1:0] vsrc,
    input  logic [NUM_SLOT-1:0]            von,
    output logic [NUM_SLOT-1:0]            hit
);
    localparam int EXT_N = 1 << SRC_W;

    logic [EXT_N-1:0] pend_ext;
    assign pend_ext = EXT_N'(pend);

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
        assign hit[g] = von[g] && pend_ext[vsrc[g]];
    end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl #(
    parameter int NUM_SRC  = 22,
    parameter int NUM_SLOT = 16,
    parameter int DATA_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         irq_src,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [vic_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       irq_req_o,
    output logic                       fiq_req_o,
    output logic [DATA_W-1:0]          cur_vector
);
    import vic_pkg::*;

    localparam int SRC_W   = $clog2(NUM_SRC);
    localparam int SLOT_IW = $clog2(NUM_SLOT);
    localparam int LVL_N   = NUM_SLOT + 1;          // slots plus default level
    localparam int LVL_W   = $clog2(LVL_N + 1);

    typedef struct packed {
        logic [NUM_SRC-1:0]              en;
        logic [NUM_SRC-1:0]              route;
        logic [DATA_W-1:0]               dflt;
        logic [NUM_SLOT-1:0][DATA_W-1:0] vaddr;
        logic [NUM_SLOT-1:0][SRC_W-1:0]  vsrc;
        logic [NUM_SLOT-1:0]             von;
        logic [LVL_N-1:0]                svc;
    } state_t;

    state_t s_q, s_d;

    // request qualification
    logic [NUM_SRC-1:0]  pend_norm;
    logic [NUM_SRC-1:0]  pend_fast;
    logic [NUM_SLOT-1:0] hit;
    logic                win_found;
    logic [SLOT_IW-1:0]  win_idx;
    logic                svc_any;
    logic [LVL_W-1:0]    svc_idx;
    logic [LVL_W-1:0]    cand_lvl;
    logic [LVL_W-1:0]    top_lvl;
    logic                cand_valid;
    logic                irq_now;

    assign pend_norm = irq_src & s_q.en & ~s_q.route;
    assign pend_fast = irq_src & s_q.en & s_q.route;

    vic_slot_match #(
        .NUM_SRC (NUM_SRC),
        .NUM_SLOT(NUM_SLOT),
        .SRC_W   (SRC_W)
    ) u_match (
        .pend(pend_norm),
        .vsrc(s_q.vsrc),
        .von (s_q.von),
        .hit (hit)
    );

    vic_prio_enc #(.W(NUM_SLOT), .IW(SLOT_IW)) u_win (
        .req  (hit),
        .found(win_found),
        .idx  (win_idx)
    );

    vic_prio_enc #(.W(LVL_N), .IW(LVL_W)) u_top (
        .req  (s_q.svc),
        .found(svc_any),
        .idx  (svc_idx)
    );

    assign cand_lvl   = win_found ? LVL_W'(win_idx) : LVL_W'(NUM_SLOT);
    assign cand_valid = |pend_norm;
    assign top_lvl    = svc_any ? svc_idx : LVL_W'(LVL_N);
    assign irq_now    = cand_valid && (cand_lvl < top_lvl);

    assign irq_req_o  = irq_now;
    assign fiq_req_o  = |pend_fast;
    assign cur_vector = (irq_now && win_found) ? s_q.vaddr[win_idx] : s_q.dflt;

    // bus decode
    logic                wr_en;
    logic                rd_en;
    logic                slot_aligned;
    logic [3:0]          slot_field;
    logic                slot_ok;
    logic [SLOT_IW-1:0]  slot_sel;

    assign wr_en        = bus_sel && bus_wr;
    assign rd_en        = bus_sel && !bus_wr;
    assign slot_aligned = (bus_addr[1:0] == 2'b00);
    assign slot_field   = bus_addr[5:2];
    assign slot_ok      = slot_aligned && (32'(slot_field) < NUM_SLOT);
    assign slot_sel     = SLOT_IW'(slot_field);

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (bus_addr)
                OFS_RAW:    bus_rdata = DATA_W'(irq_src);
                OFS_ENSET:  bus_rdata = DATA_W'(s_q.en);
                OFS_ROUTE:  bus_rdata = DATA_W'(s_q.route);
                OFS_CURVEC: bus_rdata = cur_vector;
                OFS_DFLT:   bus_rdata = s_q.dflt;
                default: begin
                    if (slot_ok && bus_addr[7:6] == REG_SLOT_ADDR) begin
                        bus_rdata = s_q.vaddr[slot_sel];
                    end else if (slot_ok && bus_addr[7:6] == REG_SLOT_CTRL) begin
                        bus_rdata = DATA_W'({s_q.von[slot_sel], s_q.vsrc[slot_sel]});
                    end
                end
            endcase
        end
    end

    // next state
    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            unique case (bus_addr)
                OFS_ENSET:  s_d.en    = s_q.en | bus_wdata[NUM_SRC-1:0];
                OFS_ENCLR:  s_d.en    = s_q.en & ~bus_wdata[NUM_SRC-1:0];
                OFS_ROUTE:  s_d.route = bus_wdata[NUM_SRC-1:0];
                OFS_CURVEC: s_d.svc   = s_q.svc & (s_q.svc - LVL_N'(1));
                OFS_DFLT:   s_d.dflt  = bus_wdata;
                default: begin
                    if (slot_ok && bus_addr[7:6] == REG_SLOT_ADDR) begin
                        s_d.vaddr[slot_sel] = bus_wdata;
                    end else if (slot_ok && bus_addr[7:6] == REG_SLOT_CTRL) begin
                        s_d.vsrc[slot_sel] = bus_wdata[SRC_W-1:0];
                        s_d.von[slot_sel]  = bus_wdata[SRC_W];
                    end
                end
            endcase
        end
        if (rd_en && bus_addr == OFS_CURVEC && irq_now) begin
            s_d.svc = s_q.svc | (LVL_N'(1) << cand_lvl);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // views for the bound checker
    logic [LVL_N-1:0]   svc_mask;
    logic [NUM_SRC-1:0] en_mask;
    assign svc_mask = s_q.svc;
    assign en_mask  = s_q.en;
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
    parameter int NUM_SRC = 22,
    parameter int LVL_N   = 17
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SRC-1:0]         irq_src,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic [vic_pkg::ADDR_W-1:0] bus_addr,
    input logic [NUM_SRC-1:0]         wd,
    input logic                       irq_req_o,
    input logic                       fiq_req_o,
    input logic [LVL_N-1:0]           svc_mask,
    input logic [NUM_SRC-1:0]         en_mask
);
    import vic_pkg::*;

    p_fast_needs_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_req_o |-> (|irq_src));

    p_norm_needs_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (|irq_src));

    p_enset_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_ENSET)
        |=> ((en_mask & $past(wd)) == $past(wd)));

    p_enclr_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_ENCLR)
        |=> ((en_mask & $past(wd)) == '0));

    p_read_latches_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_CURVEC && irq_req_o)
        |=> ($countones(svc_mask) == $past($countones(svc_mask)) + 1));

    p_eos_pops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_CURVEC && svc_mask != '0)
        |=> ($countones(svc_mask) == $past($countones(svc_mask)) - 1));
endmodule

bind vic_ctrl vic_ctrl_chk #(
    .NUM_SRC(NUM_SRC),
    .LVL_N  (NUM_SLOT + 1)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_src  (irq_src),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wd       (bus_wdata[NUM_SRC-1:0]),
    .irq_req_o(irq_req_o),
    .fiq_req_o(fiq_req_o),
    .svc_mask (svc_mask),
    .en_mask  (en_mask)
);

// File: tb/vic_ctrl_tb.sv
module vic_ctrl_tb;
    localparam int CLK_P  = 10;
    localparam int NSRC   = 22;
    localparam int NSLOT  = 16;
    localparam int DW     = 32;
    localparam logic [31:0] DEF_V = 32'hDEAD_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_src = '0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic            irq_req_o;
    logic            fiq_req_o;
    logic [DW-1:0]   cur_vector;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    vic_ctrl #(.NUM_SRC(NSRC), .NUM_SLOT(NSLOT), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req_o(irq_req_o), .fiq_req_o(fiq_req_o), .cur_vector(cur_vector)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic src(input logic [NSRC-1:0] v);
        @(negedge clk);
        irq_src = v;
        #1;
    endtask

    // slot k serves source k+3; slot 2 is left disabled
    function automatic logic [31:0] slot_addr(input int k);
        return 32'h1000 + 32'(k) * 16;
    endfunction

    function automatic int slot_of(input int s);
        if (s >= 3 && s <= 18 && s != 5) return s - 3;
        return -1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        chk("R1 irq", 32'(irq_req_o), 0);
        chk("R1 fiq", 32'(fiq_req_o), 0);
        rd(8'h04, d); chk("R1 enable", d, 0);
        rd(8'h0C, d); chk("R1 route", d, 0);
        rd(8'h14, d); chk("R1 default", d, 0);
        rd(8'h40, d); chk("R1 slot addr", d, 0);
        rd(8'hBC, d); chk("R1 slot ctrl", d, 0);
        rd(8'h10, d); chk("R1 curvec", d, 0);

        // R2 set/clear semantics
        wr(8'h04, 32'h5); wr(8'h04, 32'h2);
        rd(8'h04, d); chk("R2 set or", d, 32'h7);
        wr(8'h08, 32'h4);
        rd(8'h04, d); chk("R2 clear", d, 32'h3);
        wr(8'h08, 32'h0); wr(8'h04, 32'h0);
        rd(8'h04, d); chk("R2 zero no effect", d, 32'h3);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h04, d); chk("R2 clear all", d, 0);

        // R3 raw view before masking
        src(22'(1 << 14));
        rd(8'h00, d); chk("R3 raw", d, 32'h4000);
        chk("R3 masked irq", 32'(irq_req_o), 0);
        chk("R3 masked fiq", 32'(fiq_req_o), 0);
        wr(8'h04, 32'h4000);
        chk("R3 unmasked irq", 32'(irq_req_o), 1);
        wr(8'h08, 32'h4000);
        src('0);

        // R4 routing sweep over every source
        wr(8'h04, 32'h3F_FFFF);
        for (int s = 0; s < NSRC; s++) begin
            wr(8'h0C, 32'(1) << s);
            src(22'(1) << s);
            chk("R4 fast fiq", 32'(fiq_req_o), 1);
            chk("R4 fast irq", 32'(irq_req_o), 0);
            wr(8'h0C, 32'h0);
            chk("R4 norm fiq", 32'(fiq_req_o), 0);
            chk("R4 norm irq", 32'(irq_req_o), 1);
            src('0);
        end
        wr(8'h0C, 32'h3F_FFFF);
        src(22'(3) << 8);
        wr(8'h08, 32'h100);
        chk("R4 one enabled fiq", 32'(fiq_req_o), 1);
        src(22'(1) << 8);
        chk("R4 disabled fiq", 32'(fiq_req_o), 0);
        src('0);
        wr(8'h04, 32'h3F_FFFF);
        wr(8'h0C, 32'h0);

        // slot programming (R5): slot k -> source k+3, slot 2 disabled
        wr(8'h14, DEF_V);
        for (int k = 0; k < NSLOT; k++) begin
            wr(8'h40 + 8'(4 * k), slot_addr(k));
            wr(8'h80 + 8'(4 * k), (k == 2) ? 32'(k + 3) : (32'h20 | 32'(k + 3)));
        end
        rd(8'h80 + 8'd28, d); chk("R5 ctrl readback", d, 32'h20 | 32'd10);
        rd(8'h40 + 8'd28, d); chk("R5 addr readback", d, slot_addr(7));

        // R5/R7 single-source sweep
        for (int s = 0; s < NSRC; s++) begin
            src(22'(1) << s);
            chk("R5 irq", 32'(irq_req_o), 1);
            chk(slot_of(s) < 0 ? "R7 default vector" : "R5 slot vector",
                cur_vector, slot_of(s) < 0 ? DEF_V : slot_addr(slot_of(s)));
        end
        src('0);

        // R6 pairwise priority sweep
        for (int a = 3; a <= 18; a++) begin
            for (int b = a + 1; b <= 18; b++) begin
                int ea;
                int eb;
                int ex;
                src((22'(1) << a) | (22'(1) << b));
                ea = slot_of(a);
                eb = slot_of(b);
                ex = (ea < 0) ? eb : ((eb < 0) ? ea : ((ea < eb) ? ea : eb));
                chk("R6 lowest slot wins", cur_vector, slot_addr(ex));
            end
        end
        src('0);
        wr(8'h84, 32'h20 | 32'd12);           // slot 1 also serves source 12
        src(22'(1) << 12);
        chk("R6 shared source", cur_vector, slot_addr(1));
        wr(8'h84, 32'h20 | 32'd4);
        chk("R6 shared restored", cur_vector, slot_addr(9));
        src('0);

        // R8/R9 nesting
        src(22'(1) << 12);                     // slot 9
        rd(8'h10, d); chk("R8 read returns winner", d, slot_addr(9));
        chk("R8 same level masked", 32'(irq_req_o), 0);
        src((22'(1) << 12) | (22'(1) << 15));  // slot 12, lower priority
        chk("R8 lower level masked", 32'(irq_req_o), 0);
        src((22'(1) << 12) | (22'(1) << 15) | (22'(1) << 7)); // slot 4
        chk("R8 higher level irq", 32'(irq_req_o), 1);
        chk("R8 higher vector", cur_vector, slot_addr(4));
        rd(8'h10, d); chk("R8 nested read", d, slot_addr(4));
        chk("R8 nested masked", 32'(irq_req_o), 0);
        wr(8'h10, 32'h1234);
        chk("R9 pop re-presents", 32'(irq_req_o), 1);
        chk("R9 pop vector", cur_vector, slot_addr(4));
        src((22'(1) << 12) | (22'(1) << 15));
        chk("R9 outer still held", 32'(irq_req_o), 0);
        wr(8'h10, 32'h0);
        chk("R9 outer released", 32'(irq_req_o), 1);
        chk("R9 outer vector", cur_vector, slot_addr(9));
        src('0);
        wr(8'h10, 32'hFFFF_FFFF);              // nothing in service
        src(22'(1) << 18);
        chk("R9 empty pop no effect", 32'(irq_req_o), 1);
        src('0);

        // R7 default level ranks below slots
        src(22'(1) << 20);
        rd(8'h10, d); chk("R7 default read", d, DEF_V);
        chk("R7 default masked", 32'(irq_req_o), 0);
        src((22'(1) << 20) | (22'(1) << 18));
        chk("R7 slot over default", 32'(irq_req_o), 1);
        src(22'(1) << 20);
        wr(8'h10, 32'h0);
        chk("R7 default released", 32'(irq_req_o), 1);
        src('0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule